// File: doc/BRIEF.md
# Transmit Exception Interrupt and Shutdown Controller

This block gathers eight exception pulses from a transmit line interface into a sticky status register. Two per-bit masks classify each event. The interrupt mask decides whether a latched event drives the system interrupt. The fatal mask decides whether an event also sets a summary error bit, takes the transmit datapath offline and forces the line into continuous training.

Software clears status bits by writing ones to them. The forced shutdown holds until software drops the interface enable. The block does not generate events. An oversize burst, meaning one larger than 512 KB, is reported to it by the datapath as one of its inputs.

A small host port gives access to three registers: status at address 0, interrupt mask at address 1 and fatal mask at address 2. Writes take effect on the clock edge. Reads are combinational from the addressed register.

Top module: `txerr_sync_ctrl`

## Requirements
- R1: After a synchronous reset, status is 0, the interrupt mask is 0, the fatal mask is 0xAC (oversize burst, FIFO overflow, loss of sync and framing loss), and the irq, datapath-disable and training outputs are low.
- R2: Event input bit i sets status bit i on the next clock edge, and the bit stays set. The event order, starting from bit 0, is: calendar parity bank 0, calendar parity bank 1, oversize burst, FIFO overflow, DIP2 error, loss of sync, unexpected framing, framing loss.
- R3: A write to address 0 clears each status bit (bits 8..0) whose data bit is 1. Status bits whose data bit is 0 are unchanged, and a write never sets a status bit.
- R4: When an event and a clear of the same status bit fall in the same cycle, the bit remains set.
- R5: The irq output is high exactly when some status bit 7..0 is set and its interrupt-mask bit is 1. Events that are masked still latch into status.
- R6: Status bit 8, the summary bit, is set on the edge after any event whose fatal-mask bit is 1. Events whose fatal-mask bit is 0 do not set it.
- R7: While the interface enable is high, an event whose fatal-mask bit is set drives the datapath-disable and training outputs high from the next edge. Both stay high while the enable stays high.
- R8: With the interface enable low at an edge, the datapath-disable and training outputs are low after that edge. The summary bit is not affected.
- R9: Writes to addresses 1 and 2 load the interrupt mask and the fatal mask from data bits 7..0. Each mask reads back zero-extended. Address 3 reads 0.
- R10: A fatal event while the interface enable is low sets the summary bit but does not raise the datapath-disable or training outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 8 | Exception event pulses, one per status bit |
| if_en_i | input | 1 | Interface enable; low releases a shutdown |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | 2 | Host write address |
| wr_data_i | input | 9 | Host write data |
| rd_addr_i | input | 2 | Host read address |
| rd_data_o | output | 9 | Host read data for rd_addr_i |
| irq_o | output | 1 | System interrupt |
| dp_disable_o | output | 1 | Transmit datapath disable |
| force_train_o | output | 1 | Continuous training request |

## Verification
The bench fires an event and a write-one-to-clear on the same bit in the same cycle. A design that gave the clear priority would lose that event. It then drops the enable after a shutdown and checks that the outputs release while the summary bit stays set. A design that tied the summary bit to the shutdown latch, or that never released, fails this check. It also sends a fatal-class event with the enable low, and another after the fatal mask has been cleared, which catches designs that decode the fatal set as a constant or shut down regardless of the enable. Status writes made of zeros and masked events check that nothing gets set or raised when it should not be.

// File: rtl/txerr_pkg.sv
// Shared constants and register addresses for the transmit exception controller.
package txerr_pkg;
    localparam int EVT_N = 8;              // number of exception events
    localparam int STAT_N = EVT_N + 1;     // events plus summary bit
    localparam int REG_AW = 2;             // host address width

    // Event positions; the status bit order is fixed by these indices
    typedef enum int {
        EV_CAL_PAR0  = 0,
        EV_CAL_PAR1  = 1,
        EV_BIG_BURST = 2,
        EV_FIFO_OVF  = 3,
        EV_DIP_ERR   = 4,
        EV_SYNC_LOST = 5,
        EV_BAD_FRAME = 6,
        EV_FRAME_LOST = 7
    } evt_idx_e;

    // Host register map
    typedef enum logic [REG_AW-1:0] {
        RA_STATUS    = 2'd0,
        RA_IRQ_MASK  = 2'd1,
        RA_SYNC_MASK = 2'd2
    } reg_addr_e;

    // Default fatal set: oversize burst, FIFO overflow, loss of sync, framing loss
    localparam logic [EVT_N-1:0] SYNC_MASK_DFLT =
        (8'd1 << EV_BIG_BURST) | (8'd1 << EV_FIFO_OVF) |
        (8'd1 << EV_SYNC_LOST) | (8'd1 << EV_FRAME_LOST);
endpackage

// File: rtl/txerr_cfg_regs.sv
// Host-writable mask registers and write-one-to-clear decode.
// Assumes one write per cycle; data is wide enough for the status register.
module txerr_cfg_regs
    import txerr_pkg::*;
#(
    parameter int EVT_W = EVT_N,
    parameter int AW = REG_AW,
    parameter logic [EVT_W-1:0] SYNC_RST = SYNC_MASK_DFLT,
    localparam int SW = EVT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [SW-1:0]    wr_data_i,
    output logic [EVT_W-1:0] irq_mask_o,
    output logic [EVT_W-1:0] sync_mask_o,
    output logic [SW-1:0]    w1c_o
);
    // Clear vector for the status register, valid only for a status write
    always_comb begin
        w1c_o = '0;
        if (wr_en_i && wr_addr_i == RA_STATUS) w1c_o = wr_data_i;
    end

    // Mask registers: load on write to their address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_mask_o  <= '0;
            sync_mask_o <= SYNC_RST;
        end else if (wr_en_i) begin
            if (wr_addr_i == RA_IRQ_MASK)  irq_mask_o  <= wr_data_i[EVT_W-1:0];
            if (wr_addr_i == RA_SYNC_MASK) sync_mask_o <= wr_data_i[EVT_W-1:0];
        end
    end

    // R9: a write to the interrupt-mask address loads that mask
    a_r9_irq_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == RA_IRQ_MASK) |=> (irq_mask_o == $past(wr_data_i[EVT_W-1:0])));
endmodule

// File: rtl/txerr_status.sv
// Sticky status bits with write-one-to-clear; an event in the same cycle wins.
// The top bit is the summary of fatal-classified events.
module txerr_status
    import txerr_pkg::*;
#(
    parameter int EVT_W = EVT_N,
    localparam int SW = EVT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic [EVT_W-1:0] sync_mask_i,
    input  logic [SW-1:0]    w1c_i,
    output logic [SW-1:0]    stat_q,
    output logic             fatal_hit_o
);
    logic [SW-1:0] set_v;

    // Set vector: raw events plus the summary of fatal events
    always_comb begin
        fatal_hit_o = |(evt_i & sync_mask_i);
        set_v = {fatal_hit_o, evt_i};
    end

    // One sticky cell per status bit
    for (genvar g = 0; g < SW; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          stat_q[g] <= 1'b0;
            else if (set_v[g])   stat_q[g] <= 1'b1;
            else if (w1c_i[g])   stat_q[g] <= 1'b0;
        end
    end

    // R2/R4: every event is latched on the next edge, even with a clear pending
    a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat_q[EVT_W-1:0] & $past(evt_i)) == $past(evt_i)));

    // R3: a clear without a coincident event leaves the bit low
    a_r3_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((w1c_i & ~set_v) != '0) |=> ((stat_q & $past(w1c_i & ~set_v)) == '0));

    // R6: a fatal event sets the summary bit
    a_r6_summary_set: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_hit_o |=> stat_q[EVT_W]);
endmodule

// File: rtl/txerr_link_guard.sv
// Shutdown latch driving datapath disable and forced training.
// Assumes the interface enable is a level from software; low releases the latch.
module txerr_link_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic if_en_i,
    input  logic fatal_hit_i,
    output logic shut_q
);
    // Latch a fatal event while enabled; enable low releases
    always_ff @(posedge clk) begin
        if (!rst_n)          shut_q <= 1'b0;
        else if (!if_en_i)   shut_q <= 1'b0;
        else if (fatal_hit_i) shut_q <= 1'b1;
    end

    // R7: fatal event while enabled shuts the link next cycle
    a_r7_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        (if_en_i && fatal_hit_i) |=> shut_q);

    // R8: enable low releases the shutdown
    a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
        !if_en_i |=> !shut_q);

    // R7: the shutdown holds while the enable stays high
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (shut_q && if_en_i) |=> shut_q);
endmodule

// File: rtl/txerr_sync_ctrl.sv
// Top: transmit exception interrupt and shutdown controller.
// Collects events into sticky status, raises irq per mask, and forces link
// shutdown on fatal-classified events. Host reads are combinational.
module txerr_sync_ctrl
    import txerr_pkg::*;
#(
    parameter int EVT_W = EVT_N,
    parameter int AW = REG_AW,
    parameter logic [EVT_W-1:0] SYNC_RST = SYNC_MASK_DFLT,
    localparam int SW = EVT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] evt_i,
    input  logic             if_en_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [SW-1:0]    wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [SW-1:0]    rd_data_o,
    output logic             irq_o,
    output logic             dp_disable_o,
    output logic             force_train_o
);
    logic [EVT_W-1:0] irq_mask;
    logic [EVT_W-1:0] sync_mask;
    logic [SW-1:0]    w1c;
    logic [SW-1:0]    stat_q;
    logic             fatal_hit;
    logic             shut_q;

    txerr_cfg_regs #(.EVT_W(EVT_W), .AW(AW), .SYNC_RST(SYNC_RST)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .irq_mask_o  (irq_mask),
        .sync_mask_o (sync_mask),
        .w1c_o       (w1c)
    );

    txerr_status #(.EVT_W(EVT_W)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .sync_mask_i (sync_mask),
        .w1c_i       (w1c),
        .stat_q      (stat_q),
        .fatal_hit_o (fatal_hit)
    );

    txerr_link_guard u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .if_en_i     (if_en_i),
        .fatal_hit_i (fatal_hit),
        .shut_q      (shut_q)
    );

    // Interrupt and link outputs from registered state
    always_comb begin
        irq_o         = |(stat_q[EVT_W-1:0] & irq_mask);
        dp_disable_o  = shut_q;
        force_train_o = shut_q;
    end

    // Host read multiplexer
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            RA_STATUS:    rd_data_o = stat_q;
            RA_IRQ_MASK:  rd_data_o[EVT_W-1:0] = irq_mask;
            RA_SYNC_MASK: rd_data_o[EVT_W-1:0] = sync_mask;
            default:      rd_data_o = '0;
        endcase
    end

    // R10: with the enable low, no shutdown follows any event
    a_r10_no_shut_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_en_i) |=> !dp_disable_o);
endmodule

// File: tb/txerr_sync_ctrl_tb.sv
// Scoreboard bench: driver tasks update a reference model and queue the
// expected outputs; a monitor compares after each clock edge.
module txerr_sync_ctrl_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] evt_i = '0;
    logic       if_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_addr_i = '0;
    logic [8:0] wr_data_i = '0;
    logic [1:0] rd_addr_i = '0;
    logic [8:0] rd_data_o;
    logic       irq_o, dp_disable_o, force_train_o;

    always #(CLK_P/2) clk = ~clk;

    txerr_sync_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .if_en_i(if_en_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .irq_o(irq_o),
        .dp_disable_o(dp_disable_o), .force_train_o(force_train_o)
    );

    typedef struct packed {
        logic [8:0] rd;
        logic       irq;
        logic       dp;
        logic       tr;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    // Reference model state
    logic [8:0] m_stat;
    logic [7:0] m_imask, m_smask;
    logic       m_shut;
    logic       cur_en = 1'b0;

    // Drive one cycle and queue the expected outputs after the next edge
    task automatic step(input logic rst, input logic [7:0] ev, input logic wr,
                        input logic [1:0] wa, input logic [8:0] wd,
                        input logic [1:0] ra, input string tag);
        logic [8:0] clr;
        exp_t e;
        @(negedge clk);
        rst_n = rst; evt_i = ev; if_en_i = cur_en; wr_en_i = wr;
        wr_addr_i = wa; wr_data_i = wd; rd_addr_i = ra;
        if (!rst) begin
            m_stat = '0; m_imask = '0; m_smask = 8'hAC; m_shut = 1'b0;
        end else begin
            clr = (wr && wa == 2'd0) ? wd : 9'd0;
            m_shut = !cur_en ? 1'b0 : (m_shut | (|(ev & m_smask)));
            m_stat = (m_stat & ~clr) | {|(ev & m_smask), ev};
            if (wr && wa == 2'd1) m_imask = wd[7:0];
            if (wr && wa == 2'd2) m_smask = wd[7:0];
        end
        case (ra)
            2'd0: e.rd = m_stat;
            2'd1: e.rd = {1'b0, m_imask};
            2'd2: e.rd = {1'b0, m_smask};
            default: e.rd = '0;
        endcase
        e.irq = |(m_stat[7:0] & m_imask);
        e.dp = m_shut;
        e.tr = m_shut;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk);
    endtask

    task automatic ev(input logic [7:0] e, input logic [1:0] ra, input string tag);
        step(1'b1, e, 1'b0, 2'd0, 9'd0, ra, tag);
    endtask

    task automatic wreg(input logic [1:0] a, input logic [8:0] d, input logic [7:0] e,
                        input logic [1:0] ra, input string tag);
        step(1'b1, e, 1'b1, a, d, ra, tag);
    endtask

    // Monitor: compare one queued item per edge, away from the edge
    initial begin
        exp_t  e;
        string t;
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (rd_data_o !== e.rd || irq_o !== e.irq ||
                    dp_disable_o !== e.dp || force_train_o !== e.tr) begin
                    n_bad++;
                    $display("FAIL %s: got rd=%h irq=%b dp=%b tr=%b exp rd=%h irq=%b dp=%b tr=%b",
                             t, rd_data_o, irq_o, dp_disable_o, force_train_o,
                             e.rd, e.irq, e.dp, e.tr);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, all registers read back
        step(1'b0, 8'h00, 1'b0, 2'd0, 9'd0, 2'd0, "R1 reset status");
        step(1'b0, 8'h00, 1'b0, 2'd0, 9'd0, 2'd2, "R1 reset fatal mask");
        ev(8'h00, 2'd1, "R1 reset irq mask");
        ev(8'h00, 2'd0, "R1 status after reset");

        // R2/R7: walk each event with the enable high
        cur_en = 1'b1;
        for (int i = 0; i < 8; i++) ev(8'd1 << i, 2'd0, "R2 R7 event walk");
        ev(8'h00, 2'd0, "R2 sticky hold");

        // R3: partial clear
        wreg(2'd0, 9'h0F0, 8'h00, 2'd0, "R3 partial clear");
        wreg(2'd0, 9'h000, 8'h00, 2'd0, "R3 zero write no change");

        // R8: enable low releases shutdown, summary remains
        cur_en = 1'b0;
        ev(8'h00, 2'd0, "R8 release keeps summary");
        cur_en = 1'b1;
        ev(8'h00, 2'd0, "R8 stays released");

        // Clear all, then R9/R5 interrupt mask
        wreg(2'd0, 9'h1FF, 8'h00, 2'd0, "R3 full clear");
        wreg(2'd1, 9'h001, 8'h00, 2'd1, "R9 irq mask load");
        ev(8'h02, 2'd0, "R5 masked event no irq");
        ev(8'h01, 2'd0, "R5 unmasked event irq");

        // R4: event and clear of the same bit together
        wreg(2'd0, 9'h003, 8'h01, 2'd0, "R4 event beats clear");
        wreg(2'd0, 9'h001, 8'h00, 2'd0, "R3 clear drops irq");

        // R10: fatal event while disabled
        cur_en = 1'b0;
        ev(8'h80, 2'd0, "R10 fatal while disabled");
        cur_en = 1'b1;
        ev(8'h00, 2'd0, "R10 no late shutdown");
        wreg(2'd0, 9'h1FF, 8'h00, 2'd0, "R3 clear before R6");

        // R6: empty fatal mask, fatal-class event has no effect on summary
        wreg(2'd2, 9'h000, 8'h00, 2'd2, "R9 fatal mask load");
        ev(8'h80, 2'd0, "R6 non-fatal no summary");

        // R6/R7: reclassify DIP error as fatal
        wreg(2'd2, 9'h010, 8'h00, 2'd2, "R9 fatal mask readback");
        ev(8'h10, 2'd0, "R6 R7 DIP now fatal");
        ev(8'h00, 2'd3, "R9 address 3 reads zero");

        @(posedge clk);
        #(CLK_P/2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule